// File: doc/BRIEF.md
# Remote Terminal Message Descriptor DMA Sequencer

This block is the control sequencer that moves one remote-terminal message between the serial word interface and shared memory. When the terminal is enabled and a decoded command arrives, it locks onto a three-word descriptor block in memory. It reads that block in a single burst over a request/grant DMA port. It then moves the message's data words one at a time. In transmit it fetches each word from memory when the serial side asks for it. In receive it stores each word once the serial side delivers it.

When the serial side signals the end of the message, the block writes the descriptor back in a second burst. This burst stores the message status word and the advanced pointers, and steps down the message index. Several exception rules hold individual pointers at their old values. These rules cover mode codes with no data word, the two mode codes whose data word is produced inside the terminal, messages flagged in error, and an index that is already zero. A one-cycle completion pulse with an error flag closes each message.

The descriptor block at base address B holds the control word at B+0, the status list pointer at B+1 and the data pointer at B+2.

Top module: `rt_msg_dma_seq`

## Requirements
- R1: A command strobe is accepted only while `rt_enable` is 1 and the sequencer is idle. With `rt_enable` at 0 a command strobe starts no DMA access and produces no `msg_done`.
- R2: After an accepted command, the block reads base+0 (control word), then base+1 (status list pointer), then base+2 (data pointer). All three reads are in one burst with `dma_burst` at 1 and `dma_we` at 0.
- R3: A word transfers in a cycle where `dma_req`, `dma_gnt` and `dma_ack` are all 1. Until then, `dma_req`, `dma_addr` and `dma_we` hold steady. Within a burst, `dma_req` stays high from the first word to the last.
- R4: In a transmit message, each `ser_tx_req` causes one single read (`dma_burst` at 0) at data pointer + word number, counting from 0. The word read is then presented on `ser_tx_data` with a one-cycle `ser_tx_valid`.
- R5: In a receive message, each `ser_rx_valid` causes one single write of `ser_rx_data` to data pointer + word number.
- R6: The write-back is one burst of four writes in this order: the status word to the address held in the status list pointer, then base+2, then base+1, then base+0.
- R7: In a normal write-back, the data pointer advances by the command word count and the status list pointer advances by one. In the control word, the low byte (the index) decreases by one and the high byte is unchanged.
- R8: A mode-code command with a word count of 0 performs the descriptor read but no write-back. `msg_done` follows the end of the message directly.
- R9: Mode codes 18 and 19 perform no data-word access, and their write-back leaves the data pointer unchanged.
- R10: When `ser_msg_err` is 1 at the end of the message, the data pointer is written back unchanged and `msg_err` is 1 during `msg_done`.
- R11: When the index read is 0, the write-back leaves the data pointer, the status list pointer and the whole control word unchanged.
- R12: `msg_done` is a one-cycle pulse that follows either the last write-back word or, when there is no write-back, the end-of-message strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rt_enable | input | 1 | Terminal operation enable |
| cmd_valid | input | 1 | Valid decoded command strobe |
| cmd_tx | input | 1 | 1: terminal transmits (memory reads); 0: terminal receives |
| cmd_is_mode | input | 1 | Command is a mode code |
| cmd_code | input | 5 | Mode code number |
| cmd_wcount | input | 6 | Number of data words (0 to 32) |
| cmd_base | input | 16 | Descriptor block base address |
| ser_tx_req | input | 1 | Serial side needs the next transmit word |
| ser_tx_valid | output | 1 | Transmit word ready (one cycle) |
| ser_tx_data | output | 16 | Transmit word |
| ser_rx_valid | input | 1 | Received word strobe |
| ser_rx_data | input | 16 | Received word |
| ser_msg_end | input | 1 | End-of-message strobe |
| ser_msg_err | input | 1 | Message had an error (with end strobe) |
| ser_msg_status | input | 16 | Message status word (with end strobe) |
| dma_req | output | 1 | Bus request |
| dma_gnt | input | 1 | Bus grant |
| dma_ack | input | 1 | Word acknowledge |
| dma_burst | output | 1 | Request is a burst |
| dma_we | output | 1 | 1 write, 0 read |
| dma_addr | output | 16 | Word address |
| dma_wdata | output | 16 | Write data |
| dma_rdata | input | 16 | Read data, valid with acknowledge |
| msg_done | output | 1 | Message finished (one cycle) |
| msg_err | output | 1 | Error flag of the finished message |

## Verification
The bench compares the full ordered log of bus accesses against the expected one. A design that swapped the order of the read-back or write-back words, lost the burst flag, or mixed up base offsets would show up as a mismatched log entry. The exception cases each get their own message: an error part-way through a receive, an index of zero, a mode code with no data word, and mode code 18 with a stray transmit request. A design that advanced a pointer it should have held, wrapped the index below zero, or touched memory for an internally sourced word would write a wrong value or add an access. Grant latency is varied so that a design that moved on without a grant, or changed its address while waiting, writes to the wrong place. A command given while disabled must leave the bus silent.

// File: rtl/rt_desc_pkg.sv
package rt_desc_pkg;

    localparam int RT_DW    = 16;
    localparam int RT_AW    = 16;
    localparam int RT_WCW   = 6;
    localparam int RT_IDXW  = 8;
    localparam int RT_CODEW = 5;

    localparam logic [RT_WCW-1:0]   CNT_DESC_LAST = RT_WCW'(2);
    localparam logic [RT_WCW-1:0]   CNT_WB_LAST   = RT_WCW'(3);
    localparam logic [RT_AW-1:0]    OFS_CTRL      = RT_AW'(0);
    localparam logic [RT_AW-1:0]    OFS_MSL       = RT_AW'(1);
    localparam logic [RT_AW-1:0]    OFS_DLP       = RT_AW'(2);
    localparam logic [RT_CODEW-1:0] MC_INT_A      = RT_CODEW'(18);
    localparam logic [RT_CODEW-1:0] MC_INT_B      = RT_CODEW'(19);

    typedef enum logic [2:0] {
        ST_IDLE, ST_DESC, ST_WAIT, ST_XFER, ST_WB, ST_DONE
    } seq_state_e;

    typedef struct packed {
        logic                tx;
        logic                is_mode;
        logic [RT_CODEW-1:0] code;
        logic [RT_WCW-1:0]   wcount;
        logic [RT_AW-1:0]    base;
    } cmd_t;

    typedef struct packed {
        logic [RT_DW-1:0] ctrl;
        logic [RT_AW-1:0] msl;
        logic [RT_AW-1:0] dlp;
    } desc_t;

    function automatic logic f_internal_word(cmd_t c);
        return c.is_mode && (c.code == MC_INT_A || c.code == MC_INT_B);
    endfunction

    function automatic logic f_no_writeback(cmd_t c);
        return c.is_mode && (c.wcount == '0);
    endfunction

    function automatic logic [RT_DW-1:0] f_step_ctrl(logic [RT_DW-1:0] w);
        if (w[RT_IDXW-1:0] == '0) return w;
        return {w[RT_DW-1:RT_IDXW], w[RT_IDXW-1:0] - 1'b1};
    endfunction

endpackage

// File: rtl/rt_seq_fsm.sv
module rt_seq_fsm
    import rt_desc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rt_enable,
    input  logic              cmd_valid,
    input  cmd_t              cmd_in,
    input  logic              word_done,
    input  logic              ser_tx_req,
    input  logic              ser_rx_valid,
    input  logic              ser_msg_end,
    output seq_state_e        state,
    output logic [RT_WCW-1:0] cnt,
    output cmd_t              cmd_q,
    output logic              rx_take,
    output logic              end_take
);

    logic need_data;
    logic tx_take;

    assign need_data = (cnt < cmd_q.wcount) && !f_internal_word(cmd_q);
    assign end_take  = (state == ST_WAIT) && ser_msg_end;
    assign rx_take   = (state == ST_WAIT) && !ser_msg_end && need_data &&
                       !cmd_q.tx && ser_rx_valid;
    assign tx_take   = (state == ST_WAIT) && !ser_msg_end && need_data &&
                       cmd_q.tx && ser_tx_req;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            cnt   <= '0;
            cmd_q <= '0;
        end else begin
            case (state)
                ST_IDLE: if (cmd_valid && rt_enable) begin
                    cmd_q <= cmd_in;
                    cnt   <= '0;
                    state <= ST_DESC;
                end
                ST_DESC: if (word_done) begin
                    if (cnt == CNT_DESC_LAST) begin
                        cnt   <= '0;
                        state <= ST_WAIT;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_WAIT: begin
                    if (end_take) begin
                        cnt   <= '0;
                        state <= f_no_writeback(cmd_q) ? ST_DONE : ST_WB;
                    end else if (rx_take || tx_take) begin
                        state <= ST_XFER;
                    end
                end
                ST_XFER: if (word_done) begin
                    cnt   <= cnt + 1'b1;
                    state <= ST_WAIT;
                end
                ST_WB: if (word_done) begin
                    if (cnt == CNT_WB_LAST) state <= ST_DONE;
                    else                    cnt   <= cnt + 1'b1;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R1: a disabled terminal never leaves idle
    p_disabled_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && !rt_enable) |=> (state == ST_IDLE));

endmodule

// File: rtl/rt_desc_store.sv
module rt_desc_store
    import rt_desc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  seq_state_e        state,
    input  logic [RT_WCW-1:0] cnt,
    input  cmd_t              cmd_q,
    input  logic              word_done,
    input  logic [RT_DW-1:0]  dma_rdata,
    input  logic              rx_take,
    input  logic              end_take,
    input  logic [RT_DW-1:0]  ser_rx_data,
    input  logic [RT_DW-1:0]  msg_status,
    input  logic              msg_err_in,
    output logic [RT_AW-1:0]  dma_addr,
    output logic [RT_DW-1:0]  dma_wdata,
    output logic [RT_DW-1:0]  ser_tx_data,
    output logic              ser_tx_valid,
    output logic              msg_err
);

    desc_t            desc;
    logic [RT_DW-1:0] rx_q;
    logic [RT_DW-1:0] msw_q;
    logic             idx_zero;
    logic             hold_dlp;
    logic [RT_AW-1:0] dlp_next;
    logic [RT_AW-1:0] msl_next;
    logic [RT_DW-1:0] ctrl_next;

    always_ff @(posedge clk) begin
        if (rst) begin
            desc         <= '0;
            rx_q         <= '0;
            msw_q        <= '0;
            msg_err      <= 1'b0;
            ser_tx_data  <= '0;
            ser_tx_valid <= 1'b0;
        end else begin
            ser_tx_valid <= 1'b0;
            if (state == ST_DESC && word_done) begin
                case (cnt[1:0])
                    2'd0:    desc.ctrl <= dma_rdata;
                    2'd1:    desc.msl  <= RT_AW'(dma_rdata);
                    default: desc.dlp  <= RT_AW'(dma_rdata);
                endcase
            end
            if (rx_take) rx_q <= ser_rx_data;
            if (end_take) begin
                msw_q   <= msg_status;
                msg_err <= msg_err_in;
            end
            if (state == ST_XFER && cmd_q.tx && word_done) begin
                ser_tx_data  <= dma_rdata;
                ser_tx_valid <= 1'b1;
            end
        end
    end

    assign idx_zero  = (desc.ctrl[RT_IDXW-1:0] == '0);
    assign hold_dlp  = msg_err || f_internal_word(cmd_q) || idx_zero;
    assign dlp_next  = hold_dlp ? desc.dlp : desc.dlp + RT_AW'(cmd_q.wcount);
    assign msl_next  = idx_zero ? desc.msl : desc.msl + 1'b1;
    assign ctrl_next = f_step_ctrl(desc.ctrl);

    always_comb begin
        dma_addr  = '0;
        dma_wdata = '0;
        case (state)
            ST_DESC: dma_addr = cmd_q.base + RT_AW'(cnt);
            ST_XFER: begin
                dma_addr  = desc.dlp + RT_AW'(cnt);
                dma_wdata = rx_q;
            end
            ST_WB: begin
                case (cnt[1:0])
                    2'd0: begin dma_addr = desc.msl;                 dma_wdata = msw_q; end
                    2'd1: begin dma_addr = cmd_q.base + OFS_DLP;     dma_wdata = RT_DW'(dlp_next); end
                    2'd2: begin dma_addr = cmd_q.base + OFS_MSL;     dma_wdata = RT_DW'(msl_next); end
                    default: begin dma_addr = cmd_q.base + OFS_CTRL; dma_wdata = ctrl_next; end
                endcase
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/rt_msg_dma_seq.sv
module rt_msg_dma_seq
    import rt_desc_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                rt_enable,
    input  logic                cmd_valid,
    input  logic                cmd_tx,
    input  logic                cmd_is_mode,
    input  logic [RT_CODEW-1:0] cmd_code,
    input  logic [RT_WCW-1:0]   cmd_wcount,
    input  logic [RT_AW-1:0]    cmd_base,
    input  logic                ser_tx_req,
    output logic                ser_tx_valid,
    output logic [RT_DW-1:0]    ser_tx_data,
    input  logic                ser_rx_valid,
    input  logic [RT_DW-1:0]    ser_rx_data,
    input  logic                ser_msg_end,
    input  logic                ser_msg_err,
    input  logic [RT_DW-1:0]    ser_msg_status,
    output logic                dma_req,
    input  logic                dma_gnt,
    input  logic                dma_ack,
    output logic                dma_burst,
    output logic                dma_we,
    output logic [RT_AW-1:0]    dma_addr,
    output logic [RT_DW-1:0]    dma_wdata,
    input  logic [RT_DW-1:0]    dma_rdata,
    output logic                msg_done,
    output logic                msg_err
);

    seq_state_e        state;
    logic [RT_WCW-1:0] cnt;
    cmd_t              cmd_in;
    cmd_t              cmd_q;
    logic              rx_take;
    logic              end_take;
    logic              word_done;

    always_comb begin
        cmd_in.tx      = cmd_tx;
        cmd_in.is_mode = cmd_is_mode;
        cmd_in.code    = cmd_code;
        cmd_in.wcount  = cmd_wcount;
        cmd_in.base    = cmd_base;
    end

    assign dma_req   = (state == ST_DESC) || (state == ST_XFER) || (state == ST_WB);
    assign dma_burst = (state == ST_DESC) || (state == ST_WB);
    assign dma_we    = (state == ST_WB) || (state == ST_XFER && !cmd_q.tx);
    assign word_done = dma_req && dma_gnt && dma_ack;
    assign msg_done  = (state == ST_DONE);

    rt_seq_fsm u_fsm (
        .clk          (clk),
        .rst          (rst),
        .rt_enable    (rt_enable),
        .cmd_valid    (cmd_valid),
        .cmd_in       (cmd_in),
        .word_done    (word_done),
        .ser_tx_req   (ser_tx_req),
        .ser_rx_valid (ser_rx_valid),
        .ser_msg_end  (ser_msg_end),
        .state        (state),
        .cnt          (cnt),
        .cmd_q        (cmd_q),
        .rx_take      (rx_take),
        .end_take     (end_take)
    );

    rt_desc_store u_store (
        .clk          (clk),
        .rst          (rst),
        .state        (state),
        .cnt          (cnt),
        .cmd_q        (cmd_q),
        .word_done    (word_done),
        .dma_rdata    (dma_rdata),
        .rx_take      (rx_take),
        .end_take     (end_take),
        .ser_rx_data  (ser_rx_data),
        .msg_status   (ser_msg_status),
        .msg_err_in   (ser_msg_err),
        .dma_addr     (dma_addr),
        .dma_wdata    (dma_wdata),
        .ser_tx_data  (ser_tx_data),
        .ser_tx_valid (ser_tx_valid),
        .msg_err      (msg_err)
    );

    // R3: an unfinished request keeps its address and direction
    p_req_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (dma_req && !word_done) |=> (dma_req && $stable(dma_addr) && $stable(dma_we)));

    // R4: a transmit word is offered only after a completed read
    p_tx_valid_src_r4: assert property (@(posedge clk) disable iff (rst)
        ser_tx_valid |-> $past(word_done && !dma_we));

    // R8: mode code without data goes straight to completion
    p_skip_wb_r8: assert property (@(posedge clk) disable iff (rst)
        (end_take && f_no_writeback(cmd_q)) |=> (msg_done && !dma_req));

    // R12: completion follows a finished transfer or the end strobe
    p_done_src_r12: assert property (@(posedge clk) disable iff (rst)
        msg_done |-> ($past(word_done) || $past(end_take)));

    p_done_pulse_r12: assert property (@(posedge clk) disable iff (rst)
        msg_done |=> !msg_done);

endmodule

// File: tb/rt_msg_dma_seq_bench.sv
module rt_msg_dma_seq_bench;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rt_enable = 1'b0;
    logic        cmd_valid = 1'b0;
    logic        cmd_tx = 1'b0;
    logic        cmd_is_mode = 1'b0;
    logic [4:0]  cmd_code = '0;
    logic [5:0]  cmd_wcount = '0;
    logic [15:0] cmd_base = '0;
    logic        ser_tx_req = 1'b0;
    logic        ser_tx_valid;
    logic [15:0] ser_tx_data;
    logic        ser_rx_valid = 1'b0;
    logic [15:0] ser_rx_data = '0;
    logic        ser_msg_end = 1'b0;
    logic        ser_msg_err = 1'b0;
    logic [15:0] ser_msg_status = '0;
    logic        dma_req;
    logic        dma_gnt = 1'b0;
    logic        dma_ack = 1'b0;
    logic        dma_burst;
    logic        dma_we;
    logic [15:0] dma_addr;
    logic [15:0] dma_wdata;
    logic [15:0] dma_rdata = '0;
    logic        msg_done;
    logic        msg_err;

    int checks = 0;
    int errors = 0;
    int gnt_lat = 0;
    int lat_cnt = 0;
    int req_cycles = 0;
    int tx_seen = 0;
    int done_seen = 0;
    int log_n = 0;
    int cycles = 0;
    logic [15:0] mem [0:255];
    logic        log_we [0:31];
    logic [15:0] log_addr [0:31];
    logic [15:0] log_data [0:31];
    logic        log_burst [0:31];

    rt_msg_dma_seq u_rt_msg_dma_seq (
        .clk(clk), .rst(rst), .rt_enable(rt_enable), .cmd_valid(cmd_valid),
        .cmd_tx(cmd_tx), .cmd_is_mode(cmd_is_mode), .cmd_code(cmd_code),
        .cmd_wcount(cmd_wcount), .cmd_base(cmd_base), .ser_tx_req(ser_tx_req),
        .ser_tx_valid(ser_tx_valid), .ser_tx_data(ser_tx_data),
        .ser_rx_valid(ser_rx_valid), .ser_rx_data(ser_rx_data),
        .ser_msg_end(ser_msg_end), .ser_msg_err(ser_msg_err),
        .ser_msg_status(ser_msg_status), .dma_req(dma_req), .dma_gnt(dma_gnt),
        .dma_ack(dma_ack), .dma_burst(dma_burst), .dma_we(dma_we),
        .dma_addr(dma_addr), .dma_wdata(dma_wdata), .dma_rdata(dma_rdata),
        .msg_done(msg_done), .msg_err(msg_err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // memory and arbiter model, evaluated between edges
    always @(negedge clk) begin
        cycles++;
        if (rst || !dma_req) begin
            dma_gnt = 1'b0; dma_ack = 1'b0; lat_cnt = 0;
        end else if (lat_cnt < gnt_lat) begin
            lat_cnt++; dma_gnt = 1'b0; dma_ack = 1'b0;
        end else begin
            dma_gnt = 1'b1; dma_ack = 1'b1;
            if (dma_we) mem[dma_addr[7:0]] = dma_wdata;
            else        dma_rdata = mem[dma_addr[7:0]];
            if (log_n < 32) begin
                log_we[log_n]    = dma_we;
                log_addr[log_n]  = dma_addr;
                log_data[log_n]  = dma_we ? dma_wdata : mem[dma_addr[7:0]];
                log_burst[log_n] = dma_burst;
            end
            log_n++;
        end
        if (!rst) begin
            if (dma_req)      req_cycles++;
            if (ser_tx_valid) tx_seen++;
            if (msg_done)     done_seen++;
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic chk_log(input int i, input logic we, input logic [15:0] addr,
                           input logic [15:0] data, input logic burst, input string tag);
        check($sformatf("%s entry %0d", tag, i),
              {log_we[i], log_burst[i], log_addr[i], log_data[i]}, {we, burst, addr, data});
    endtask

    task automatic chk_desc_read(input logic [15:0] base, input string tag);
        for (int i = 0; i < 3; i++)
            chk_log(i, 1'b0, base + 16'(i), mem[base[7:0] + 8'(i)], 1'b1, tag);
    endtask

    task automatic send_cmd(input logic tx, input logic is_mode, input logic [4:0] code,
                            input logic [5:0] wc, input logic [15:0] base);
        log_n = 0;
        @(negedge clk);
        cmd_tx = tx; cmd_is_mode = is_mode; cmd_code = code;
        cmd_wcount = wc; cmd_base = base; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        repeat (15) @(negedge clk);
    endtask

    task automatic rx_word(input logic [15:0] d);
        ser_rx_valid = 1'b1; ser_rx_data = d;
        @(negedge clk);
        ser_rx_valid = 1'b0;
        repeat (10) @(negedge clk);
    endtask

    task automatic tx_word(input logic [15:0] exp, input string tag);
        bit got = 0;
        ser_tx_req = 1'b1;
        @(negedge clk);
        ser_tx_req = 1'b0;
        for (int i = 0; i < 20 && !got; i++) begin
            if (ser_tx_valid) begin
                got = 1;
                check(tag, ser_tx_data, exp);
            end else @(negedge clk);
        end
        check({tag, " valid seen"}, got, 1);
        repeat (5) @(negedge clk);
    endtask

    task automatic end_msg(input logic err, input logic [15:0] st, input string tag);
        bit got = 0;
        ser_msg_end = 1'b1; ser_msg_err = err; ser_msg_status = st;
        @(negedge clk);
        ser_msg_end = 1'b0; ser_msg_err = 1'b0;
        for (int i = 0; i < 40 && !got; i++) begin
            if (msg_done) got = 1;
            else @(negedge clk);
        end
        check({tag, " R12 done seen"}, got, 1);
        check({tag, " R10 msg_err"}, msg_err, err);
        @(negedge clk);
        check({tag, " R12 done one cycle"}, msg_done, 0);
    endtask

    task automatic t_reset;
        check("R12 reset msg_done", msg_done, 0);
        check("R3 reset dma_req", dma_req, 0);
        check("R4 reset tx_valid", ser_tx_valid, 0);
        check("R10 reset msg_err", msg_err, 0);
    endtask

    task automatic t_disabled;
        int r0 = req_cycles; int d0 = done_seen;
        rt_enable = 1'b0;
        send_cmd(1'b0, 1'b0, 5'd0, 6'd2, 16'h0010);
        repeat (10) @(negedge clk);
        check("R1 no request while disabled", req_cycles, r0);
        check("R1 no done while disabled", done_seen, d0);
        rt_enable = 1'b1;
    endtask

    task automatic t_rx_normal;
        mem[8'h10] = 16'hA505; mem[8'h11] = 16'h0040; mem[8'h12] = 16'h0080;
        gnt_lat = 0;
        send_cmd(1'b0, 1'b0, 5'd0, 6'd3, 16'h0010);
        chk_desc_read(16'h0010, "R2 rx desc");
        rx_word(16'h1111); rx_word(16'h2222); rx_word(16'h3333);
        end_msg(1'b0, 16'h0C00, "rx");
        check("R5 rx count", log_n, 10);
        chk_log(3, 1'b1, 16'h0080, 16'h1111, 1'b0, "R5 rx w0");
        chk_log(4, 1'b1, 16'h0081, 16'h2222, 1'b0, "R5 rx w1");
        chk_log(5, 1'b1, 16'h0082, 16'h3333, 1'b0, "R5 rx w2");
        chk_log(6, 1'b1, 16'h0040, 16'h0C00, 1'b1, "R6 rx status");
        chk_log(7, 1'b1, 16'h0012, 16'h0083, 1'b1, "R7 rx dlp");
        chk_log(8, 1'b1, 16'h0011, 16'h0041, 1'b1, "R7 rx msl");
        chk_log(9, 1'b1, 16'h0010, 16'hA504, 1'b1, "R7 rx ctrl");
    endtask

    task automatic t_tx_slow_grant;
        mem[8'h20] = 16'h3302; mem[8'h21] = 16'h0050; mem[8'h22] = 16'h0090;
        mem[8'h90] = 16'hBEEF; mem[8'h91] = 16'hCAFE;
        gnt_lat = 3;
        send_cmd(1'b1, 1'b0, 5'd0, 6'd2, 16'h0020);
        chk_desc_read(16'h0020, "R2 tx desc");
        tx_word(16'hBEEF, "R4 tx w0");
        tx_word(16'hCAFE, "R4 tx w1");
        end_msg(1'b0, 16'h0400, "tx");
        check("R3 tx count", log_n, 9);
        chk_log(3, 1'b0, 16'h0090, 16'hBEEF, 1'b0, "R4 tx rd0");
        chk_log(4, 1'b0, 16'h0091, 16'hCAFE, 1'b0, "R4 tx rd1");
        chk_log(5, 1'b1, 16'h0050, 16'h0400, 1'b1, "R6 tx status");
        chk_log(6, 1'b1, 16'h0022, 16'h0092, 1'b1, "R7 tx dlp");
        chk_log(7, 1'b1, 16'h0021, 16'h0051, 1'b1, "R7 tx msl");
        chk_log(8, 1'b1, 16'h0020, 16'h3301, 1'b1, "R7 tx ctrl");
        gnt_lat = 0;
    endtask

    task automatic t_error;
        mem[8'h30] = 16'h0004; mem[8'h31] = 16'h0060; mem[8'h32] = 16'h00A0;
        gnt_lat = 1;
        send_cmd(1'b0, 1'b0, 5'd0, 6'd4, 16'h0030);
        rx_word(16'h5A5A);
        end_msg(1'b1, 16'h8000, "err");
        check("R10 err count", log_n, 8);
        chk_log(3, 1'b1, 16'h00A0, 16'h5A5A, 1'b0, "R5 err w0");
        chk_log(4, 1'b1, 16'h0060, 16'h8000, 1'b1, "R6 err status");
        chk_log(5, 1'b1, 16'h0032, 16'h00A0, 1'b1, "R10 err dlp held");
        chk_log(6, 1'b1, 16'h0031, 16'h0061, 1'b1, "R10 err msl");
        chk_log(7, 1'b1, 16'h0030, 16'h0003, 1'b1, "R10 err ctrl");
        gnt_lat = 0;
    endtask

    task automatic t_index_zero;
        mem[8'h40] = 16'h7700; mem[8'h41] = 16'h0070; mem[8'h42] = 16'h00B0;
        send_cmd(1'b0, 1'b0, 5'd0, 6'd1, 16'h0040);
        rx_word(16'h0F0F);
        end_msg(1'b0, 16'h0001, "idx0");
        check("R11 idx0 count", log_n, 8);
        chk_log(5, 1'b1, 16'h0042, 16'h00B0, 1'b1, "R11 idx0 dlp");
        chk_log(6, 1'b1, 16'h0041, 16'h0070, 1'b1, "R11 idx0 msl");
        chk_log(7, 1'b1, 16'h0040, 16'h7700, 1'b1, "R11 idx0 ctrl");
    endtask

    task automatic t_mode_nodata;
        mem[8'h48] = 16'h0003; mem[8'h49] = 16'h0074; mem[8'h4A] = 16'h00B8;
        send_cmd(1'b1, 1'b1, 5'd1, 6'd0, 16'h0048);
        chk_desc_read(16'h0048, "R2 mode desc");
        end_msg(1'b0, 16'h0000, "mode0");
        check("R8 no writeback", log_n, 3);
        check("R8 ctrl untouched", mem[8'h48], 16'h0003);
    endtask

    task automatic t_mode_internal;
        int t0;
        mem[8'h4C] = 16'h0102; mem[8'h4D] = 16'h0078; mem[8'h4E] = 16'h00C0;
        send_cmd(1'b1, 1'b1, 5'd18, 6'd1, 16'h004C);
        t0 = tx_seen;
        ser_tx_req = 1'b1;
        @(negedge clk);
        ser_tx_req = 1'b0;
        repeat (15) @(negedge clk);
        check("R9 no data access", log_n, 3);
        check("R9 no tx word", tx_seen, t0);
        end_msg(1'b0, 16'h0200, "mc18");
        check("R9 count", log_n, 7);
        chk_log(3, 1'b1, 16'h0078, 16'h0200, 1'b1, "R6 mc18 status");
        chk_log(4, 1'b1, 16'h004E, 16'h00C0, 1'b1, "R9 mc18 dlp held");
        chk_log(5, 1'b1, 16'h004D, 16'h0079, 1'b1, "R9 mc18 msl");
        chk_log(6, 1'b1, 16'h004C, 16'h0101, 1'b1, "R9 mc18 ctrl");
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_disabled();
        t_rx_normal();
        t_tx_slow_grant();
        t_error();
        t_index_zero();
        t_mode_nodata();
        t_mode_internal();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        wait (cycles > 100000);
        checks++;
        errors++;
        $display("FAIL watchdog: got %0d cycles expected completion", cycles);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule